// File: doc/BRIEF.md
# Scoreboarded In-Order Issue Controller for ADD/MUL

This block sequences a stream of three-register arithmetic instructions through fetch, decode, execute and writeback. An instruction is accepted from the input stream in its fetch cycle and spends the next cycle in a single decode slot. It leaves that slot to begin execute only when three things hold: its operands can be delivered, the unit it needs is free, and its destination has no write still outstanding. There are two execution units, an adder and a multiplier. Each takes a fixed number of cycles and neither is pipelined.

A per-register pending bit records every write that has been issued but not yet committed. A single writeback register commits one result per cycle into an internal register file. The `fwd_en` input picks how a dependent instruction gets its operand. When it is high, the dependent takes the value straight from the producing unit's output. When it is low, the dependent waits until the producer's writeback has happened. A free-running cycle counter gives a time base for measuring schedules, and a combinational read port exposes the register file.

Top module: `sb_issue_core`

## Requirements
- R1: An instruction accepted in cycle F with no hazards is in decode in cycle F+1 and executes from cycle F+2. It appears on `wb_valid`/`wb_rd`/`wb_data` in cycle F+2+L, where L is its unit latency and cycle numbers are the values of `cycle_count`.
- R2: `in_op`=0 selects ADD, with L=4 and result `in_rs1`+`in_rs2` modulo 2^W. `in_op`=1 selects MUL, with L=6 and result equal to the low W bits of the product. `in_rd` names the destination and `in_rs1`/`in_rs2` name the sources.
- R3: Neither unit is pipelined. A new operation starts execute on a unit no earlier than the cycle in which that unit's previous result occupies the writeback register.
- R4: With `fwd_en`=0, a consumer of a register starts execute no earlier than the cycle after that register's producer has its writeback cycle.
- R5: With `fwd_en`=1, a consumer starts execute no earlier than the cycle after its producer's last execute cycle, and it uses the forwarded value.
- R6: Issue is in program order. A stalled instruction stays in decode and holds `in_ready` low, so no younger instruction is accepted.
- R7: An instruction whose destination still has an uncommitted write starts execute no earlier than the cycle after that write's writeback cycle.
- R8: At most one result is written back per cycle. When both units are ready in the same cycle, the older instruction wins. The other result stays in its unit, and the unit stays occupied until a later writeback cycle takes it.
- R9: After reset, register i holds the value i. A result is visible on `rf_data` from the cycle after its writeback cycle.
- R10: `cycle_count` reads 0 in the first cycle after reset is released and increases by one every cycle.
- R11: During reset, `in_ready` is 1, `wb_valid` is 0 and `cycle_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en | input | 1 | 1: forward from unit output; 0: operands only after writeback |
| in_valid | input | 1 | Instruction offered this cycle |
| in_op | input | 1 | 0 = ADD, 1 = MUL |
| in_rd | input | log2(NREG) | Destination register |
| in_rs1 | input | log2(NREG) | First source register |
| in_rs2 | input | log2(NREG) | Second source register |
| in_ready | output | 1 | Offered instruction is taken at this clock edge |
| wb_valid | output | 1 | A result is committed this cycle |
| wb_rd | output | log2(NREG) | Register being written |
| wb_data | output | W | Value being written |
| rf_addr | input | log2(NREG) | Register file read address |
| rf_data | output | W | Register file read data |
| cycle_count | output | CW | Cycles since reset release |

## Verification
The assertions watch several invariants on every cycle. A stalled instruction must hold steady in decode, and a busy unit must count down by exactly one each cycle. Writeback may only target a register marked pending, and it must both clear that mark and land in the register file. Without forwarding, nothing may issue while its source is still uncommitted. The cycle counter must step by one. Other properties cannot be stated locally and are left to the bench's scenarios. These include the exact cycle of every writeback under each operand-delivery mode, the older-first outcome when both units finish in the same cycle, the delay caused by a destination conflict, and the arithmetic values. The bench checks them against an independently computed schedule.

// File: rtl/sb_issue_core.sv
`timescale 1ns/1ps
module sb_issue_core #(
  parameter int NREG    = 16,
  parameter int W       = 16,
  parameter int ADD_LAT = 4,
  parameter int MUL_LAT = 6,
  parameter int CW      = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fwd_en,
  input  logic                    in_valid,
  input  logic                    in_op,
  input  logic [$clog2(NREG)-1:0] in_rd,
  input  logic [$clog2(NREG)-1:0] in_rs1,
  input  logic [$clog2(NREG)-1:0] in_rs2,
  output logic                    in_ready,
  output logic                    wb_valid,
  output logic [$clog2(NREG)-1:0] wb_rd,
  output logic [W-1:0]            wb_data,
  input  logic [$clog2(NREG)-1:0] rf_addr,
  output logic [W-1:0]            rf_data,
  output logic [CW-1:0]           cycle_count
);
  localparam int RA = $clog2(NREG);
  localparam int MAXLAT = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
  localparam int LW = $clog2(MAXLAT + 1);

  logic [W-1:0]    rf [NREG];
  logic [NREG-1:0] pend;

  logic          d_valid, d_op;
  logic [RA-1:0] d_rd, d_rs1, d_rs2;

  logic [1:0]    u_busy;
  logic [LW-1:0] u_cnt [2];
  logic [RA-1:0] u_rd  [2];
  logic [W-1:0]  u_res [2];
  logic          add_first;

  logic [1:0] fin, grant, ufree;
  logic       issue, ok1, ok2, dst_ok;
  logic [W-1:0] op_a, op_b, sum, prod;

  for (genvar k = 0; k < 2; k++) begin : g_unit
    assign fin[k]   = u_busy[k] && (u_cnt[k] == LW'(1));
    assign ufree[k] = !u_busy[k] || grant[k];
  end

  assign grant[0] = fin[0] && (!fin[1] || add_first);
  assign grant[1] = fin[1] && !grant[0];

  function automatic logic src_ready(input logic [RA-1:0] r);
    src_ready = !pend[r] || (wb_valid && wb_rd == r) ||
                (fwd_en && ((fin[0] && u_rd[0] == r) || (fin[1] && u_rd[1] == r)));
  endfunction

  function automatic logic [W-1:0] src_val(input logic [RA-1:0] r);
    if (fwd_en && fin[0] && u_rd[0] == r)      src_val = u_res[0];
    else if (fwd_en && fin[1] && u_rd[1] == r) src_val = u_res[1];
    else if (wb_valid && wb_rd == r)           src_val = wb_data;
    else                                       src_val = rf[r];
  endfunction

  assign ok1    = src_ready(d_rs1);
  assign ok2    = src_ready(d_rs2);
  assign dst_ok = !pend[d_rd] || (wb_valid && wb_rd == d_rd);
  assign issue  = d_valid && ufree[d_op] && ok1 && ok2 && dst_ok;
  assign in_ready = !d_valid || issue;

  assign op_a = src_val(d_rs1);
  assign op_b = src_val(d_rs2);
  assign sum  = op_a + op_b;
  assign prod = op_a * op_b;
  assign rf_data = rf[rf_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycle_count <= '0;
      d_valid <= 1'b0;
      d_op    <= 1'b0;
      d_rd    <= '0;
      d_rs1   <= '0;
      d_rs2   <= '0;
      wb_valid <= 1'b0;
      wb_rd    <= '0;
      wb_data  <= '0;
      pend     <= '0;
      u_busy   <= '0;
      add_first <= 1'b0;
      for (int k = 0; k < 2; k++) begin
        u_cnt[k] <= '0;
        u_rd[k]  <= '0;
        u_res[k] <= '0;
      end
      for (int i = 0; i < NREG; i++) rf[i] <= W'(i);
    end else begin
      cycle_count <= cycle_count + CW'(1);
      if (in_ready) begin
        d_valid <= in_valid;
        d_op    <= in_op;
        d_rd    <= in_rd;
        d_rs1   <= in_rs1;
        d_rs2   <= in_rs2;
      end
      wb_valid <= |grant;
      if (grant[0]) begin
        wb_rd   <= u_rd[0];
        wb_data <= u_res[0];
      end else if (grant[1]) begin
        wb_rd   <= u_rd[1];
        wb_data <= u_res[1];
      end
      if (wb_valid) begin
        rf[wb_rd]   <= wb_data;
        pend[wb_rd] <= 1'b0;
      end
      if (issue) begin
        pend[d_rd] <= 1'b1;
        add_first  <= d_op;
      end
      for (int k = 0; k < 2; k++) begin
        if (issue && d_op == 1'(k)) begin
          u_busy[k] <= 1'b1;
          u_cnt[k]  <= (k == 0) ? LW'(ADD_LAT) : LW'(MUL_LAT);
          u_rd[k]   <= d_rd;
          u_res[k]  <= (k == 0) ? sum : prod;
        end else if (grant[k]) begin
          u_busy[k] <= 1'b0;
        end else if (u_busy[k] && u_cnt[k] > LW'(1)) begin
          u_cnt[k] <= u_cnt[k] - LW'(1);
        end
      end
    end
  end

  a_r6_decode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && !issue |=> d_valid && $stable(d_op) && $stable(d_rd) && $stable(d_rs1) && $stable(d_rs2));

  for (genvar k = 0; k < 2; k++) begin : g_chk
    a_r3_unit_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      u_busy[k] && u_cnt[k] > LW'(1) |=> u_busy[k] && u_cnt[k] == $past(u_cnt[k]) - LW'(1));
  end

  a_r8_wb_to_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> pend[wb_rd]);

  a_r7_wb_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !(issue && d_rd == wb_rd) |=> !pend[$past(wb_rd)]);

  a_r9_rf_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> rf[$past(wb_rd)] == $past(wb_data));

  a_r4_no_early_use: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en && issue |-> (!pend[d_rs1] || (wb_valid && wb_rd == d_rs1)) &&
                         (!pend[d_rs2] || (wb_valid && wb_rd == d_rs2)));

  a_r10_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cycle_count == $past(cycle_count) + CW'(1));
endmodule

// File: tb/test_sb_issue_core.sv
`timescale 1ns/1ps
module test_sb_issue_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fwd_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_op = 1'b0;
  logic [3:0]  in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic        in_ready;
  logic        wb_valid;
  logic [3:0]  wb_rd;
  logic [15:0] wb_data;
  logic [3:0]  rf_addr = '0;
  logic [15:0] rf_data;
  logic [31:0] cycle_count;

  always #10 clk = ~clk;

  sb_issue_core i_sb_issue_core (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en),
    .in_valid(in_valid), .in_op(in_op), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_ready(in_ready), .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
    .rf_addr(rf_addr), .rf_data(rf_data), .cycle_count(cycle_count)
  );

  typedef struct { int rd; int val; int cyc; } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, tcyc = 0;
  bit finished = 0;
  string ttag = "R1";

  int p_op[8], p_rd[8], p_a[8], p_b[8];
  int mf[8], me[8], mw[8];
  int m[16];

  always @(posedge clk) begin
    if (!rst_n) tcyc = 0;
    else tcyc = tcyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(negedge clk) begin
    if (rst_n && wb_valid) begin
      if (q.size() == 0) begin
        chk(0, "R8", "unexpected writeback rd", wb_rd, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(wb_rd == e.rd, "R2", "writeback register", wb_rd, e.rd);
        chk(wb_data == 16'(e.val), "R2", "writeback data", wb_data, e.val);
        chk(tcyc == e.cyc, {"R1/", ttag}, "writeback cycle", tcyc, e.cyc);
        chk(cycle_count == tcyc, "R10", "cycle counter", cycle_count, tcyc);
      end
    end
  end

  task automatic ld(input int i, input int op, input int rd, input int a, input int b);
    p_op[i] = op; p_rd[i] = rd; p_a[i] = a; p_b[i] = b;
  endtask

  function automatic int mx(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  task automatic model(input int n, input bit fwd);
    int lastw[16], lastel[16], unitw[2];
    int maxw = 0;
    for (int r = 0; r < 16; r++) begin
      lastw[r] = -10; lastel[r] = -10; m[r] = r;
    end
    unitw[0] = -10; unitw[1] = -10;
    for (int i = 0; i < n; i++) begin
      int lat, e, w, v;
      bit hit;
      lat = p_op[i] ? 6 : 4;
      mf[i] = (i == 0) ? 0 : mx(mf[i-1] + 1, me[i-1] - 1);
      e = mx(mf[i] + 2, unitw[p_op[i]]);
      if (fwd) e = mx(e, mx(lastel[p_a[i]], lastel[p_b[i]]));
      else     e = mx(e, mx(lastw[p_a[i]] + 1, lastw[p_b[i]] + 1));
      e = mx(e, lastw[p_rd[i]] + 1);
      w = e + lat;
      do begin
        hit = 0;
        for (int j = 0; j < i; j++) if (mw[j] == w) hit = 1;
        if (hit) w++;
      end while (hit);
      v = p_op[i] ? ((m[p_a[i]] * m[p_b[i]]) & 16'hffff) : ((m[p_a[i]] + m[p_b[i]]) & 16'hffff);
      m[p_rd[i]] = v;
      me[i] = e; mw[i] = w;
      lastw[p_rd[i]] = w; lastel[p_rd[i]] = e + lat; unitw[p_op[i]] = w;
      if (w > maxw) maxw = w;
    end
    for (int c = 0; c <= maxw; c++)
      for (int j = 0; j < n; j++)
        if (mw[j] == c) begin
          exp_t x;
          int vv;
          vv = 0;
          x.rd = p_rd[j]; x.cyc = c;
          for (int k = 0; k <= j; k++)
            if (k == j) vv = 1;
          x.val = 0;
          q.push_back(x);
        end
  endtask

  task automatic fill_values(input int n);
    int r[16];
    int idx;
    for (int k = 0; k < 16; k++) r[k] = k;
    for (int i = 0; i < n; i++) begin
      int v;
      v = p_op[i] ? ((r[p_a[i]] * r[p_b[i]]) & 16'hffff) : ((r[p_a[i]] + r[p_b[i]]) & 16'hffff);
      r[p_rd[i]] = v;
      idx = 0;
      for (int k = 0; k < q.size(); k++) begin
        exp_t x;
        x = q[k];
        if (x.cyc == mw[i] && x.rd == p_rd[i]) begin
          x.val = v;
          q[k] = x;
        end
      end
    end
  endtask

  task automatic run(input int n, input bit fwd, input string tag);
    in_valid = 0;
    rst_n = 0;
    fwd_en = fwd;
    ttag = tag;
    q.delete();
    repeat (2) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R11", "in_ready in reset", in_ready, 1);
    chk(wb_valid == 1'b0, "R11", "wb_valid in reset", wb_valid, 0);
    chk(cycle_count == 0, "R11", "cycle_count in reset", cycle_count, 0);
    rf_addr = 4'd9;
    #1;
    chk(rf_data == 16'd9, "R9", "reset register value", rf_data, 9);
    model(n, fwd);
    fill_values(n);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < n; i++) begin
      in_valid = 1;
      in_op = p_op[i][0];
      in_rd = 4'(p_rd[i]); in_rs1 = 4'(p_a[i]); in_rs2 = 4'(p_b[i]);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      chk(tcyc == mf[i], "R6", "accept cycle", tcyc, mf[i]);
      @(negedge clk);
    end
    in_valid = 0;
    for (int k = 0; k < 80 && q.size() > 0; k++) @(negedge clk);
    chk(q.size() == 0, "R8", "writebacks outstanding", q.size(), 0);
    repeat (2) @(negedge clk);
    for (int r = 0; r < 16; r++) begin
      rf_addr = 4'(r);
      #1;
      chk(rf_data == 16'(m[r]), "R9", "final register", rf_data, m[r]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    // R3 / R1: independent work, unit occupancy
    ld(0, 0, 1, 2, 3); ld(1, 0, 4, 5, 6); ld(2, 1, 7, 8, 9); ld(3, 1, 10, 11, 12);
    run(4, 0, "R3");
    // R4: dependent program, operands only after writeback
    ld(0, 1, 3, 1, 2); ld(1, 0, 5, 4, 3); ld(2, 0, 6, 4, 1);
    ld(3, 1, 7, 8, 9); ld(4, 0, 4, 3, 7); ld(5, 1, 10, 5, 6);
    run(6, 0, "R4");
    // R5: same program with forwarding
    run(6, 1, "R5");
    // R8: both units finish together, older multiply wins
    ld(0, 1, 1, 2, 3); ld(1, 0, 4, 5, 6); ld(2, 0, 7, 5, 6);
    ld(3, 1, 8, 1, 2); ld(4, 0, 9, 5, 5); ld(5, 0, 10, 9, 4);
    run(6, 0, "R8");
    run(6, 1, "R8");
    // R7: destination conflict, then forwarded consumer
    ld(0, 1, 1, 2, 3); ld(1, 0, 1, 4, 5); ld(2, 0, 6, 1, 1);
    run(3, 1, "R7");
    finished = 1;
    summary();
    $finish;
  end
endmodule